// File: doc/BRIEF.md
# Configurable Pin Interrupt Unit

The unit turns a bank of asynchronous general-purpose input pins into up to eight independent interrupt requests. All pins of the bank first pass through a two-stage synchronizer. Each channel then picks one synchronized pin through its own selector and watches it in one of two ways:

- **Edge mode:** the channel records rising and/or falling transitions in sticky flags, which software clears by writing ones.
- **Level mode:** the request simply follows the pin, inverted when the channel is set active-low.

Every channel has its own interrupt line. A wake output is raised whenever any channel requests service, so a sleeping system can be roused.

Software reaches the unit through a small register port. A write is taken on the clock edge while the write strobe is high, and reads are combinational from the address. With the default of eight channels the map is:

| Address | Access | Content |
|---|---|---|
| 0 to 7 | read/write | Configuration word, one per channel |
| 8 | write-1-to-clear | Rise flag vector |
| 9 | write-1-to-clear | Fall flag vector |
| 10 | read-only | Request vector |

Top module: `pin_irq_unit`

## Requirements
- R1: After reset every configuration word reads 0, both flag vectors read 0, and `irq_o` and `wake_o` are low.
- R2: The configuration word at address c (0..7) has these fields: bits [5:0] pin select, bit 8 level mode (1 = level, 0 = edge), bit 9 rise enable, bit 10 fall enable, bit 11 active-low. These bits read back as written and all other bits read 0. Without a write the configuration never changes.
- R3: A pin change driven between two clock edges reaches a level-mode request after the second following rising edge, not after the first.
- R4: In edge mode, a rising transition sets bit c of the rise flag vector (address 8) only when rise enable is 1. A falling transition sets bit c of the fall flag vector (address 9) only when fall enable is 1. A transition whose enable is 0 sets nothing.
- R5: In edge mode, `irq_o[c]` is high exactly while the channel's rise flag or fall flag is set, and it stays high after the pin returns.
- R6: Writing 1 to bit c of address 8 or 9 clears that flag. Bits written as 0 leave their flags unchanged.
- R7: When a flag's clear write and a new enabled edge on that channel fall in the same cycle, the flag remains set.
- R8: In level mode, `irq_o[c]` equals the synchronized pin XOR active-low, with no latching, and the channel never sets flags. Toggling active-low therefore withdraws an active request at once.
- R9: A write that changes a channel's pin select or mode clears both of its flags. It also produces no edge from the difference between the old pin and the new pin.
- R10: `wake_o` is high whenever any bit of `irq_o` is high and low when none is.
- R11: Address 10 reads the request vector `irq_o` in its low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 64 | Asynchronous pin bank |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 8 | One interrupt request per channel |
| wake_o | output | 1 | OR of all requests |

## Verification
Each channel keeps three bits of state: the previous pin sample and the two sticky flags.

- **Stale previous sample:** if this bit is left over from an old pin after a reselect, a spurious rise or fall flag appears at the flag registers and on `irq_o` within one cycle of the write.
- **Flag lost or stuck:** a flag that drops under a simultaneous clear, or that survives a clear, shows on the flag read-back and the request line on the very next read.
- **Synchronizer depth:** a synchronizer that is too short or too deep moves the level request off its second-edge slot by one cycle, and the bench samples that exact slot.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    localparam int SEL_W = 6;

    typedef struct packed {
        logic             act_low;
        logic             fall_en;
        logic             rise_en;
        logic             lvl_mode;
        logic [SEL_W-1:0] sel;
    } chan_cfg_t;

    // Pack a channel configuration into its 32-bit register image.
    function automatic logic [31:0] cfg_to_word(chan_cfg_t c);
        return {20'd0, c.act_low, c.fall_en, c.rise_en, c.lvl_mode, 2'd0, c.sel};
    endfunction

    // Extract a channel configuration from a 32-bit register image.
    function automatic chan_cfg_t word_to_cfg(logic [31:0] w);
        chan_cfg_t c;
        c.sel      = w[SEL_W-1:0];
        c.lvl_mode = w[8];
        c.rise_en  = w[9];
        c.fall_en  = w[10];
        c.act_low  = w[11];
        return c;
    endfunction

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;

    // R3: the second stage always takes what the first stage held one cycle earlier
    a_r3_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.s2 == $past(st_q.s1)));

endmodule

// File: rtl/pin_irq_chan.sv
module pin_irq_chan
    import pin_irq_pkg::*;
#(
    parameter int NUM_PINS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] bank_i,
    input  chan_cfg_t           cfg_i,
    input  logic [SEL_W-1:0]    new_sel_i,
    input  logic                reconf_i,
    input  logic                clr_rise_i,
    input  logic                clr_fall_i,
    output logic                irq_o,
    output logic                rise_o,
    output logic                fall_o
);

    typedef struct packed {
        logic prev;
        logic rise;
        logic fall;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     cur_lvl;
    logic     new_lvl;
    logic     rise_evt;
    logic     fall_evt;

    // Selected pin; out-of-range selects read as low.
    function automatic logic pick(logic [NUM_PINS-1:0] bank, logic [SEL_W-1:0] s);
        logic v;
        v = 1'b0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (s == SEL_W'(p)) begin
                v = bank[p];
            end
        end
        return v;
    endfunction

    always_comb begin
        cur_lvl  = pick(bank_i, cfg_i.sel);
        new_lvl  = pick(bank_i, new_sel_i);
        rise_evt = !cfg_i.lvl_mode && cfg_i.rise_en &&  cur_lvl && !st_q.prev;
        fall_evt = !cfg_i.lvl_mode && cfg_i.fall_en && !cur_lvl &&  st_q.prev;

        st_d      = st_q;
        st_d.prev = cur_lvl;
        if (reconf_i) begin
            st_d.prev = new_lvl;
            st_d.rise = 1'b0;
            st_d.fall = 1'b0;
        end else begin
            st_d.rise = rise_evt || (st_q.rise && !clr_rise_i);
            st_d.fall = fall_evt || (st_q.fall && !clr_fall_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.rise;
    assign fall_o = st_q.fall;
    assign irq_o  = cfg_i.lvl_mode ? (cur_lvl ^ cfg_i.act_low) : (st_q.rise | st_q.fall);

    // R7: an enabled edge wins over a simultaneous clear
    a_r7_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_evt && !reconf_i) |=> st_q.rise);

    // R6: a clear with no competing edge drops the flag
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rise_i && !rise_evt && !reconf_i) |=> !st_q.rise);

    // R9: reselecting the pin or mode empties both flags
    a_r9_reconf_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reconf_i |=> (!st_q.rise && !st_q.fall));

    // R8: a level-mode channel holds no flags
    a_r8_level_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i.lvl_mode |-> (!st_q.rise && !st_q.fall));

endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
    import pin_irq_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic [NUM_CH-1:0] irq_o,
    output logic              wake_o
);

    localparam int RISE_ADR = NUM_CH;
    localparam int FALL_ADR = NUM_CH + 1;
    localparam int IRQ_ADR  = NUM_CH + 2;

    chan_cfg_t [NUM_CH-1:0] cfg_d, cfg_q;
    chan_cfg_t              wr_cfg;
    logic [NUM_CH-1:0]      reconf;
    logic [NUM_CH-1:0]      clr_rise;
    logic [NUM_CH-1:0]      clr_fall;
    logic [NUM_CH-1:0]      rise_vec;
    logic [NUM_CH-1:0]      fall_vec;
    logic [NUM_PINS-1:0]    pin_sync;

    pin_irq_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    // Register writes: configuration update, reselect detection, flag clears.
    always_comb begin
        wr_cfg   = word_to_cfg(32'(reg_wdata_i));
        cfg_d    = cfg_q;
        reconf   = '0;
        clr_rise = '0;
        clr_fall = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_we_i && reg_addr_i == ADDR_W'(c)) begin
                cfg_d[c]  = wr_cfg;
                reconf[c] = (wr_cfg.sel != cfg_q[c].sel) ||
                            (wr_cfg.lvl_mode != cfg_q[c].lvl_mode);
            end
        end
        if (reg_we_i && reg_addr_i == ADDR_W'(RISE_ADR)) begin
            clr_rise = reg_wdata_i[NUM_CH-1:0];
        end
        if (reg_we_i && reg_addr_i == ADDR_W'(FALL_ADR)) begin
            clr_fall = reg_wdata_i[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Combinational read-back.
    always_comb begin
        reg_rdata_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr_i == ADDR_W'(c)) begin
                reg_rdata_o = DATA_W'(cfg_to_word(cfg_q[c]));
            end
        end
        if (reg_addr_i == ADDR_W'(RISE_ADR)) begin
            reg_rdata_o[NUM_CH-1:0] = rise_vec;
        end
        if (reg_addr_i == ADDR_W'(FALL_ADR)) begin
            reg_rdata_o[NUM_CH-1:0] = fall_vec;
        end
        if (reg_addr_i == ADDR_W'(IRQ_ADR)) begin
            reg_rdata_o[NUM_CH-1:0] = irq_o;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pin_irq_chan #(.NUM_PINS(NUM_PINS)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .bank_i     (pin_sync),
            .cfg_i      (cfg_q[g]),
            .new_sel_i  (wr_cfg.sel),
            .reconf_i   (reconf[g]),
            .clr_rise_i (clr_rise[g]),
            .clr_fall_i (clr_fall[g]),
            .irq_o      (irq_o[g]),
            .rise_o     (rise_vec[g]),
            .fall_o     (fall_vec[g])
        );
    end

    assign wake_o = |irq_o;

    // R2: configuration only moves on a write
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we_i |=> $stable(cfg_q));

endmodule

// File: tb/sim_pin_irq_unit.sv
module sim_pin_irq_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pin_i = '0;
    logic        reg_we_i = 1'b0;
    logic [3:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [7:0]  irq_o;
    logic        wake_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_irq_unit u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin_i),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o),
        .wake_o      (wake_o)
    );

    // Vector layout: [17:15] ch, [14:9] pin, [8] level, [7] rise_en, [6] fall_en,
    // [5] act_low, [4] start level, [3] end level, [2] exp irq, [1] exp rise, [0] exp fall
    localparam logic [17:0] VEC [9] = '{
        {3'd0, 6'd5,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R4 rise seen
        {3'd1, 6'd63, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 fall ignored
        {3'd2, 6'd10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R4 fall seen
        {3'd3, 6'd20, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R5 both, rise
        {3'd3, 6'd20, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R5 both, fall
        {3'd4, 6'd33, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R8 high active
        {3'd5, 6'd40, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 low active
        {3'd6, 6'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 high idle
        {3'd7, 6'd62, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}  // R4 no enables
    };

    function automatic logic [31:0] mk_cfg(int sel, bit lvl, bit re, bit fe, bit al);
        return {20'd0, al, fe, re, lvl, 2'd0, 6'(sel)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic wr(input int a, input logic [31:0] d);
        reg_we_i    = 1'b1;
        reg_addr_i  = 4'(a);
        reg_wdata_i = d;
        @(negedge clk);
        reg_we_i    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr_i = 4'(a);
        #1;
        d = reg_rdata_o;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {24'd0, irq_o}, 32'd0);
        chk("R1 wake", {31'd0, wake_o}, 32'd0);
        rd(8, r);  chk("R1 rise flags", r, 32'd0);
        rd(9, r);  chk("R1 fall flags", r, 32'd0);
        rd(3, r);  chk("R1 cfg", r, 32'd0);

        // Table walk: R4, R5, R8
        for (int i = 0; i < 9; i++) begin
            automatic logic [17:0] v = VEC[i];
            automatic int ch = int'(v[17:15]);
            automatic int pn = int'(v[14:9]);
            pin_i[pn] = v[4];
            idle(4);
            wr(ch, mk_cfg(pn, v[8], v[7], v[6], v[5]));
            wr(8, 32'hFF);
            wr(9, 32'hFF);
            idle(2);
            pin_i[pn] = v[3];
            idle(4);
            chk($sformatf("R5/R8 vec%0d irq", i), {31'd0, irq_o[ch]}, {31'd0, v[2]});
            rd(8, r); chk($sformatf("R4 vec%0d rise", i), {31'd0, r[ch]}, {31'd0, v[1]});
            rd(9, r); chk($sformatf("R4 vec%0d fall", i), {31'd0, r[ch]}, {31'd0, v[0]});
            if (v[2]) chk($sformatf("R10 vec%0d wake", i), {31'd0, wake_o}, 32'd1);
        end

        // R3 synchronizer latency on a level channel
        pin_i[7] = 1'b0;
        wr(0, mk_cfg(7, 1, 0, 0, 0));
        idle(3);
        pin_i[7] = 1'b1;
        @(negedge clk);
        chk("R3 after first edge", {31'd0, irq_o[0]}, 32'd0);
        @(negedge clk);
        chk("R3 after second edge", {31'd0, irq_o[0]}, 32'd1);

        // R8 acknowledge by polarity flip
        wr(0, mk_cfg(7, 1, 0, 0, 1));
        chk("R8 flip withdraws", {31'd0, irq_o[0]}, 32'd0);
        rd(8, r); chk("R8 no rise flag", {31'd0, r[0]}, 32'd0);

        // R2 read-back, R11 request vector
        rd(0, r); chk("R2 readback", r, mk_cfg(7, 1, 0, 0, 1));
        wr(0, mk_cfg(7, 1, 0, 0, 0));
        rd(10, r); chk("R11 irq vector bit0", {31'd0, r[0]}, 32'd1);

        // R7 edge coincident with clear
        pin_i[12] = 1'b0;
        wr(1, mk_cfg(12, 0, 1, 0, 0));
        idle(3);
        pin_i[12] = 1'b1;
        idle(4);
        pin_i[12] = 1'b0;
        idle(4);
        pin_i[12] = 1'b1;
        idle(2);
        wr(8, 32'h2);
        rd(8, r); chk("R7 edge wins", {31'd0, r[1]}, 32'd1);

        // R6 zero bits leave flags, one bit clears
        wr(8, 32'hFD);
        rd(8, r); chk("R6 zero bit keeps", {31'd0, r[1]}, 32'd1);
        wr(8, 32'h2);
        rd(8, r); chk("R6 one bit clears", {31'd0, r[1]}, 32'd0);
        chk("R6 irq drops", {31'd0, irq_o[1]}, 32'd0);

        // R9 reselect clears flags, no edge from pin difference
        pin_i[12] = 1'b0;
        idle(4);
        pin_i[12] = 1'b1;
        idle(4);
        rd(8, r); chk("R9 flag before", {31'd0, r[1]}, 32'd1);
        pin_i[12] = 1'b0;
        pin_i[13] = 1'b1;
        idle(4);
        wr(1, mk_cfg(13, 0, 1, 0, 0));
        rd(8, r); chk("R9 cleared", {31'd0, r[1]}, 32'd0);
        idle(4);
        rd(8, r); chk("R9 no false edge", {31'd0, r[1]}, 32'd0);
        chk("R9 irq low", {31'd0, irq_o[1]}, 32'd0);

        // R10 wake follows requests
        for (int c = 0; c < 8; c++) begin
            wr(c, mk_cfg(48 + c, 0, 0, 0, 0));
        end
        chk("R10 all idle irq", {24'd0, irq_o}, 32'd0);
        chk("R10 wake low", {31'd0, wake_o}, 32'd0);
        wr(2, mk_cfg(50, 1, 0, 0, 0));
        pin_i[50] = 1'b1;
        idle(3);
        chk("R10 wake high", {31'd0, wake_o}, 32'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule